// File: doc/BRIEF.md
# Supply Monitor Control Logic

This block is the digital controller that sits around an analog supply-voltage comparator. Software sets it up through a small register interface. It chooses an operating mode, a sampling period and a calibration trim. It also has a one-shot lock that freezes that setup until the next reset. The block then powers the comparator in one of two ways. It either keeps it on all the time, or it powers it in short bursts paced by a slow reference clock. From the comparator result it keeps a below-threshold flag, raises a masked interrupt on the flag's rising edge, and in one mode requests a system reset.

Sampling bursts are used in the two deepest sleep states, or at any time when software forces them. In every other state the comparator runs all the time. The slow reference is modelled as a one-cycle tick enable in the register clock domain. The comparator output is asynchronous and is synchronized before use. The factory trim value comes in on a port and is captured on the first clock after reset. While the monitor is active, the block tells the separate power-on detector to stand down.

Top module: `supply_mon_ctrl`

## Requirements
- R1: While reset is asserted all outputs are low and the configuration word (address 0) reads 0. This means the mode is off, the block is unlocked and the interrupt mask is clear.
- R2: On the first clock after reset the trim field (cfg bits 15:8) is loaded from calib_factory_i and the trim-done bit (cfg bit 18) becomes 1 and stays 1. A later write to the trim field replaces the value.
- R3: Writing a 1 to cfg bit 16 locks the configuration word. Every later write to address 0 is ignored until reset, and reset clears the lock.
- R4: The mode field (cfg bits 1:0) has these encodings: 0 is off, 1 is reset-on-drop and 2 is interrupt-only. Code 3 behaves as off. The monitor is active for codes 1 and 2 only. The active state reads back on cfg bit 17 and drives por_dis_o.
- R5: An active monitor samples when sleep_mode_i is 6 or 7, or when the force bit (cfg bit 2) is 1. osc_en_o is high exactly while sampling. An active monitor that is not sampling holds cmp_en_o high.
- R6: In sampling, cmp_en_o is high for a window of 4 slow ticks and then low for 2^(P+5) ticks, where P is cfg bits 7:4. A new sampling run starts with a window.
- R7: In continuous operation the detection flag (status bit 0, address 1) follows cmp_below_i after a two-flop synchronizer. In sampling the flag takes its value only at the tick that closes a window. While the monitor is inactive the flag holds.
- R8: irq_o pulses for one cycle when the flag goes from 0 to 1, but only while the mask is set. Writing 1 to bit 0 at address 2 sets the mask, and status bit 1 shows it.
- R9: rst_req_o is high while the mode is 1 and the flag is set. It never rises in mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 cfg, 1 status, 2 interrupt enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| sleep_mode_i | input | 3 | Current sleep state; 6 and 7 are the deepest |
| slow_tick_i | input | 1 | One-cycle pulse per slow reference period |
| cmp_below_i | input | 1 | Comparator result, 1 when the supply is below threshold (asynchronous) |
| calib_factory_i | input | 8 | Factory trim value |
| cal_o | output | 8 | Trim value sent to the comparator |
| cmp_en_o | output | 1 | Comparator power enable |
| osc_en_o | output | 1 | Slow oscillator enable |
| por_dis_o | output | 1 | Disable for the power-on detector |
| irq_o | output | 1 | Interrupt pulse |
| rst_req_o | output | 1 | System reset request |

## Verification
Some rules are checked on every cycle. osc_en_o and rst_req_o are only ever high with an active monitor of the right mode. The comparator is always powered in continuous operation. The interrupt is a single-cycle pulse. A locked configuration cannot change, the trim-done bit never falls, and the flag stays still while the monitor is inactive. Other behaviour needs the bench's scenarios and its cycle-level reference model. These are the exact window and off-interval lengths for several period codes, and the flag holding its value through an off interval while the comparator changes. They also cover mask gating and reset-request differences between modes 1 and 2, and the lock being cleared by reset.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RST  = 2'd1,
    MODE_IRQ  = 2'd2,
    MODE_RSVD = 2'd3
  } mon_mode_e;

  function automatic logic mode_active(mon_mode_e m);
    return (m == MODE_RST) || (m == MODE_IRQ);
  endfunction
endpackage

// File: rtl/smc_regs.sv
module smc_regs
  import smc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CAL_W = 8,
  parameter int PER_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CAL_W-1:0] calib_factory_i,
  input  logic             active_i,
  input  logic             det_i,
  output logic [DW-1:0]    rdata_o,
  output mon_mode_e        mode_o,
  output logic             force_o,
  output logic [PER_W-1:0] per_o,
  output logic [CAL_W-1:0] cal_o,
  output logic             lock_o,
  output logic             done_o,
  output logic             mask_o,
  output logic [PER_W+CAL_W+3:0] snap_o
);
  localparam int FORCE_BIT = 2;
  localparam int PER_LSB   = 4;
  localparam int CAL_LSB   = PER_LSB + PER_W;
  localparam int LOCK_BIT  = CAL_LSB + CAL_W;
  localparam int ON_BIT    = LOCK_BIT + 1;
  localparam int DONE_BIT  = LOCK_BIT + 2;

  mon_mode_e        mode_q;
  logic             force_q;
  logic [PER_W-1:0] per_q;
  logic [CAL_W-1:0] cal_q;
  logic             lock_q, done_q, mask_q;
  logic             cfg_wr, ien_wr;
  logic             unused_wbits;

  assign cfg_wr = we_i && (addr_i == ADDR_CFG) && !lock_q;
  assign ien_wr = we_i && (addr_i == ADDR_IEN) && wdata_i[0];
  assign unused_wbits = ^{wdata_i[DW-1:LOCK_BIT+1], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      force_q <= 1'b0;
      per_q   <= '0;
      cal_q   <= '0;
      lock_q  <= 1'b0;
      done_q  <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      if (cfg_wr) begin
        mode_q  <= mon_mode_e'(wdata_i[1:0]);
        force_q <= wdata_i[FORCE_BIT];
        per_q   <= wdata_i[PER_LSB +: PER_W];
        cal_q   <= wdata_i[CAL_LSB +: CAL_W];
        lock_q  <= wdata_i[LOCK_BIT];
      end
      // factory load takes precedence on the first cycle out of reset
      if (!done_q) begin
        cal_q  <= calib_factory_i;
        done_q <= 1'b1;
      end
      if (ien_wr) mask_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CFG: begin
        rdata_o[1:0]               = mode_q;
        rdata_o[FORCE_BIT]         = force_q;
        rdata_o[PER_LSB +: PER_W]  = per_q;
        rdata_o[CAL_LSB +: CAL_W]  = cal_q;
        rdata_o[LOCK_BIT]          = lock_q;
        rdata_o[ON_BIT]            = active_i;
        rdata_o[DONE_BIT]          = done_q;
      end
      ADDR_STAT: begin
        rdata_o[0] = det_i;
        rdata_o[1] = mask_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign mode_o  = mode_q;
  assign force_o = force_q;
  assign per_o   = per_q;
  assign cal_o   = cal_q;
  assign lock_o  = lock_q;
  assign done_o  = done_q;
  assign mask_o  = mask_q;
  assign snap_o  = {lock_q, cal_q, per_q, force_q, mode_q};
endmodule

// File: rtl/smc_seq.sv
module smc_seq #(
  parameter int PER_W    = 4,
  parameter int WIN_LEN  = 4,
  parameter int OFF_BASE = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             samp_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             win_o,
  output logic             strobe_o
);
  localparam int CNT_W = (1 << PER_W) + OFF_BASE;
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int SH_W  = $clog2(CNT_W);

  logic             off_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic [CNT_W-1:0] off_cnt_q;
  logic [SH_W-1:0]  shamt;
  logic [CNT_W-1:0] off_last;
  logic             win_last;

  assign shamt    = SH_W'(period_i) + SH_W'(OFF_BASE);
  assign off_last = (CNT_W'(1) << shamt) - CNT_W'(1);
  assign win_last = (win_cnt_q == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q     <= 1'b0;
      win_cnt_q <= '0;
      off_cnt_q <= '0;
    end else if (!samp_i) begin
      off_q     <= 1'b0;
      win_cnt_q <= '0;
      off_cnt_q <= '0;
    end else if (tick_i) begin
      if (!off_q) begin
        if (win_last) begin
          off_q     <= 1'b1;
          win_cnt_q <= '0;
        end else begin
          win_cnt_q <= win_cnt_q + WIN_W'(1);
        end
      end else if (off_cnt_q == off_last) begin
        off_q     <= 1'b0;
        off_cnt_q <= '0;
      end else begin
        off_cnt_q <= off_cnt_q + CNT_W'(1);
      end
    end
  end

  assign win_o    = ~off_q;
  assign strobe_o = samp_i & tick_i & ~off_q & win_last;
endmodule

// File: rtl/smc_detect.sv
module smc_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_i,
  input  logic cont_i,
  input  logic strobe_i,
  input  logic mask_i,
  input  logic rst_mode_i,
  output logic det_o,
  output logic irq_o,
  output logic rst_req_o
);
  logic cmp_sync;
  logic det_q, det_d_q;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b0;
        else         s_q <= cmp_i;
      end
      assign cmp_sync = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[SYNC_STAGES-2:0], cmp_i};
      end
      assign cmp_sync = s_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q   <= 1'b0;
      det_d_q <= 1'b0;
    end else begin
      if (cont_i || strobe_i) det_q <= cmp_sync;
      det_d_q <= det_q;
    end
  end

  assign det_o     = det_q;
  assign irq_o     = det_q & ~det_d_q & mask_i;
  assign rst_req_o = rst_mode_i & det_q;
endmodule

// File: rtl/supply_mon_ctrl.sv
module supply_mon_ctrl
  import smc_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CAL_W       = 8,
  parameter int PER_W       = 4,
  parameter int SLEEP_W     = 3,
  parameter int DEEP_MIN    = 6,
  parameter int WIN_LEN     = 4,
  parameter int OFF_BASE    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic [SLEEP_W-1:0] sleep_mode_i,
  input  logic               slow_tick_i,
  input  logic               cmp_below_i,
  input  logic [CAL_W-1:0]   calib_factory_i,
  output logic [CAL_W-1:0]   cal_o,
  output logic               cmp_en_o,
  output logic               osc_en_o,
  output logic               por_dis_o,
  output logic               irq_o,
  output logic               rst_req_o
);
  localparam int SNAP_W = PER_W + CAL_W + 4;

  mon_mode_e        mode_q;
  logic             force_q, lock_q, cal_done, mask_q;
  logic [PER_W-1:0] per_q;
  logic [SNAP_W-1:0] cfg_snap;
  logic             mon_en, deep_sleep, samp_mode;
  logic             win_on, strobe, det_q;

  assign mon_en     = mode_active(mode_q);
  assign deep_sleep = (sleep_mode_i >= SLEEP_W'(DEEP_MIN));
  assign samp_mode  = mon_en & (force_q | deep_sleep);

  smc_regs #(.DW(DW), .CAL_W(CAL_W), .PER_W(PER_W)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .we_i           (reg_we_i),
    .addr_i         (reg_addr_i),
    .wdata_i        (reg_wdata_i),
    .calib_factory_i(calib_factory_i),
    .active_i       (mon_en),
    .det_i          (det_q),
    .rdata_o        (reg_rdata_o),
    .mode_o         (mode_q),
    .force_o        (force_q),
    .per_o          (per_q),
    .cal_o          (cal_o),
    .lock_o         (lock_q),
    .done_o         (cal_done),
    .mask_o         (mask_q),
    .snap_o         (cfg_snap)
  );

  smc_seq #(.PER_W(PER_W), .WIN_LEN(WIN_LEN), .OFF_BASE(OFF_BASE)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .samp_i  (samp_mode),
    .tick_i  (slow_tick_i),
    .period_i(per_q),
    .win_o   (win_on),
    .strobe_o(strobe)
  );

  smc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmp_i     (cmp_below_i),
    .cont_i    (mon_en & ~samp_mode),
    .strobe_i  (strobe),
    .mask_i    (mask_q),
    .rst_mode_i(mode_q == MODE_RST),
    .det_o     (det_q),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  assign cmp_en_o  = mon_en & (~samp_mode | win_on);
  assign osc_en_o  = samp_mode;
  assign por_dis_o = mon_en;
endmodule

// File: rtl/smc_checker.sv
module smc_checker #(
  parameter int SNAP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              active_i,
  input logic [1:0]        mode_i,
  input logic              lock_i,
  input logic              done_i,
  input logic              det_i,
  input logic [SNAP_W-1:0] snap_i,
  input logic              cmp_en_o,
  input logic              osc_en_o,
  input logic              por_dis_o,
  input logic              irq_o,
  input logic              rst_req_o
);
  assert_osc_needs_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_en_o |-> por_dis_o);
  assert_cont_powered_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (por_dis_o && !osc_en_o) |-> cmp_en_o);
  assert_rst_only_mode1_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (mode_i == 2'd1 && det_i));
  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_lock_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(snap_i));
  assert_done_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i);
  assert_det_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> $stable(det_i));
  assert_on_matches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_dis_o |-> (active_i && (mode_i == 2'd1 || mode_i == 2'd2)));
endmodule

bind supply_mon_ctrl smc_checker #(.SNAP_W(SNAP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .active_i (mon_en),
  .mode_i   (mode_q),
  .lock_i   (lock_q),
  .done_i   (cal_done),
  .det_i    (det_q),
  .snap_i   (cfg_snap),
  .cmp_en_o (cmp_en_o),
  .osc_en_o (osc_en_o),
  .por_dis_o(por_dis_o),
  .irq_o    (irq_o),
  .rst_req_o(rst_req_o)
);

// File: tb/supply_mon_ctrl_bench.sv
module supply_mon_ctrl_bench;
  localparam logic [7:0] FACT = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  sleep = 3'd0;
  logic        tick = 1'b0;
  logic        cmp_below = 1'b0;
  logic [7:0]  cal;
  logic        cmp_en, osc_en, por_dis, irq, rst_req;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int div = 0;
  bit run_cmp = 0;

  always #2 clk = ~clk;

  supply_mon_ctrl u_supply_mon_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sleep_mode_i(sleep),
    .slow_tick_i(tick), .cmp_below_i(cmp_below), .calib_factory_i(FACT),
    .cal_o(cal), .cmp_en_o(cmp_en), .osc_en_o(osc_en), .por_dis_o(por_dis),
    .irq_o(irq), .rst_req_o(rst_req)
  );

  // slow tick: one pulse every 4 register clocks
  always @(negedge clk) begin
    div  = (div + 1) % 4;
    tick <= (div == 0);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference model
  int m_mode, m_force, m_per, m_cal, m_lock, m_done, m_mask;
  int m_s1, m_s2, m_det, m_detp, m_off, m_wc, m_oc;

  function automatic bit m_en();
    return (m_mode == 1) || (m_mode == 2);
  endfunction
  function automatic bit m_samp();
    return m_en() && (m_force != 0 || sleep >= 3'd6);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_force = 0; m_per = 0; m_cal = 0; m_lock = 0; m_done = 0; m_mask = 0;
      m_s1 = 0; m_s2 = 0; m_det = 0; m_detp = 0; m_off = 0; m_wc = 0; m_oc = 0;
    end else begin
      bit en, smp, stb;
      en  = m_en();
      smp = m_samp();
      stb = smp && tick && m_off == 0 && m_wc == 3;
      m_detp = m_det;
      if ((en && !smp) || stb) m_det = m_s2;
      m_s2 = m_s1;
      m_s1 = cmp_below;
      if (!smp) begin
        m_off = 0; m_wc = 0; m_oc = 0;
      end else if (tick) begin
        if (m_off == 0) begin
          if (m_wc == 3) begin m_off = 1; m_wc = 0; end
          else m_wc++;
        end else if (m_oc == (1 << (m_per + 5)) - 1) begin
          m_off = 0; m_oc = 0;
        end else m_oc++;
      end
      if (we && addr == 2'd0 && m_lock == 0) begin
        m_mode = wdata[1:0]; m_force = wdata[2]; m_per = wdata[7:4];
        m_cal = wdata[15:8]; m_lock = wdata[16];
      end
      if (m_done == 0) begin m_cal = FACT; m_done = 1; end
      if (we && addr == 2'd2 && wdata[0]) m_mask = 1;
    end
  end

  always @(negedge clk) begin
    #1;
    if (run_cmp) begin
      int exp_rd;
      check("R6 cmp_en", cmp_en, m_en() && (!m_samp() || m_off == 0));
      check("R5 osc_en", osc_en, m_samp());
      check("R4 por_dis", por_dis, m_en());
      check("R8 irq", irq, m_det == 1 && m_detp == 0 && m_mask == 1);
      check("R9 rst_req", rst_req, m_mode == 1 && m_det == 1);
      check("R2 cal_o", cal, m_cal);
      if (addr == 2'd0)
        exp_rd = m_mode | (m_force << 2) | (m_per << 4) | (m_cal << 8) |
                 (m_lock << 16) | (int'(m_en()) << 17) | (m_done << 18);
      else if (addr == 2'd1) exp_rd = m_det | (m_mask << 1);
      else exp_rd = 0;
      check("R7 rdata", rdata, exp_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  function automatic logic [31:0] cfgw(int mode, int frc, int per, int c, int lk);
    return 32'(mode) | (32'(frc) << 2) | (32'(per) << 4) | (32'(c) << 8) | (32'(lk) << 16);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 2'd1;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure_low(output int n);
    n = 0;
    do @(negedge clk); while (cmp_en !== 1'b0);
    while (cmp_en === 1'b0) begin n++; @(negedge clk); end
  endtask

  task automatic measure_high(output int n);
    n = 0;
    while (cmp_en === 1'b1) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n, irqs;
    #1 rst_n = 1'b0;
    run_cmp = 1;
    wait_clk(2);
    // R1: reset state
    rd_chk(2'd0, 0, "R1 cfg in reset");
    check("R1 outputs in reset", {cmp_en, osc_en, por_dis, irq, rst_req}, 0);
    rst_n = 1'b1;
    // R2: factory trim and done bit
    rd_chk(2'd0, 32'hA5 << 8 | 1 << 18, "R2 factory load");
    wr(2'd0, cfgw(0, 0, 0, 8'h3C, 0));
    rd_chk(2'd0, 32'h3C << 8 | 1 << 18, "R2 trim override");

    // R4: mode 3 inactive, mode 2 active
    wr(2'd0, cfgw(3, 0, 0, 8'h3C, 0));
    check("R4 mode3 inactive", por_dis, 0);
    wr(2'd0, cfgw(2, 0, 0, 8'h3C, 0));
    check("R4 mode2 active", por_dis, 1);
    check("R5 continuous powered", {cmp_en, osc_en}, 2'b10);

    // R8: no interrupt while masked
    irqs = 0;
    @(negedge clk); cmp_below = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); irqs += irq; end
    check("R8 masked no irq", irqs, 0);
    rd_chk(2'd1, 1, "R7 continuous follow");
    check("R9 no reset in mode2", rst_req, 0);
    @(negedge clk); cmp_below = 1'b0;
    wait_clk(4);
    rd_chk(2'd1, 0, "R7 continuous clear");
    wr(2'd2, 32'h1);
    rd_chk(2'd1, 2, "R8 mask readback");
    irqs = 0;
    @(negedge clk); cmp_below = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); irqs += irq; end
    check("R8 single irq pulse", irqs, 1);

    // R9: reset request in mode 1
    wr(2'd0, cfgw(1, 0, 0, 8'h3C, 0));
    wait_clk(2);
    check("R9 reset request mode1", rst_req, 1);
    @(negedge clk); cmp_below = 1'b0;
    wait_clk(4);
    check("R9 request drops", rst_req, 0);

    // R7: flag holds while inactive
    @(negedge clk); cmp_below = 1'b1;
    wait_clk(4);
    wr(2'd0, cfgw(0, 0, 0, 8'h3C, 0));
    @(negedge clk); cmp_below = 1'b0;
    wait_clk(6);
    rd_chk(2'd1, 3, "R7 hold while inactive");
    wr(2'd0, cfgw(2, 0, 0, 8'h3C, 0));
    wait_clk(4);
    rd_chk(2'd1, 2, "R7 flag cleared");

    // R5/R6: deep sleep sampling, period 0
    @(negedge clk); sleep = 3'd6;
    wait_clk(1);
    check("R5 osc on in deep sleep", osc_en, 1);
    measure_low(n);
    check("R6 off interval P0", n, 128);
    measure_high(n);
    check("R6 window length", n, 16);
    // R7: flag holds during off interval
    cmp_below = 1'b1;
    wait_clk(40);
    rd_chk(2'd1, 2, "R7 held during off");
    do @(negedge clk); while (cmp_en !== 1'b1);
    do @(negedge clk); while (cmp_en !== 1'b0);
    check("R8 irq at window close", irq, 1);
    rd_chk(2'd1, 3, "R7 captured at window end");
    @(negedge clk); sleep = 3'd7;
    wait_clk(3);
    check("R5 sleep7 samples", osc_en, 1);

    // R5/R6: forced sampling in run, period 1
    @(negedge clk); sleep = 3'd0;
    wr(2'd0, cfgw(2, 0, 1, 8'h3C, 0));
    check("R5 continuous in run", osc_en, 0);
    wr(2'd0, cfgw(2, 1, 1, 8'h3C, 0));
    check("R5 forced sampling", osc_en, 1);
    measure_low(n);
    check("R6 off interval P1", n, 256);

    // R3: lock
    wr(2'd0, cfgw(2, 0, 0, 8'h44, 1));
    rd_chk(2'd0, 2 | (8'h44 << 8) | (1 << 16) | (1 << 17) | (1 << 18), "R3 lock set");
    wr(2'd0, cfgw(1, 1, 3, 8'h11, 0));
    rd_chk(2'd0, 2 | (8'h44 << 8) | (1 << 16) | (1 << 17) | (1 << 18), "R3 write ignored");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk(2'd0, 32'hA5 << 8 | 1 << 18, "R3 reset unlocks");
    wr(2'd0, cfgw(2, 0, 0, 8'h3C, 0));
    rd_chk(2'd0, 2 | (8'h3C << 8) | (1 << 17) | (1 << 18), "R3 writable after reset");

    wait_clk(4);
    finish_up();
  end
endmodule